// File: doc/BRIEF.md
# Fast Inter-Processor Interrupt Request Controller

This block delivers fast inter-processor interrupts between cores spread over several clusters. A requesting core presents a 32-bit request word on either a local path, which always aims at a core inside the requester's own cluster, or a global path, which names the destination cluster explicitly. The request word carries the destination core, the destination cluster and a delivery kind. Depending on that kind, the block marks the destination core as pending at once, arms a per-core countdown that marks it pending later, cancels an armed countdown, or marks it pending without waking an idle core.

Each core sees a level-sensitive fast-interrupt output that stays high while its pending flag is set. It also has a status write port that clears the flag when bit 0 of the written value is 1. A shared countdown register sets the delay that is loaded when a deferred request arrives. Each core also has a wake output. It is raised for an idle core only when the pending flag was set by a delivery kind that is allowed to wake.

Top module: `fipi_ctrl`

## Requirements
- R1: The request word fields are: destination core in bits [7:0], destination cluster in bits [23:16] and delivery kind in bits [29:28]. Kind 0 is immediate, 1 is retract, 2 is deferred and 3 is no-wake. Core index = cluster * CPC + core.
- R2: A local request (`req_global`=0) ignores bits [23:16] and targets the cluster of `req_src` (req_src / CPC). A global request targets the cluster in bits [23:16].
- R3: A request whose cluster is not below NCL, or whose core is not below CPC, changes no state.
- R4: Pending flags reset to 0. An immediate request sets the target's pending bit at the clock edge that samples it. `fiq` equals `pending` on every core, as a level.
- R5: A status write with bit 0 = 1 clears that core's pending bit at the next edge. A status write with bit 0 = 0 has no effect.
- R6: When a setting request and a clearing status write hit the same core on the same edge, pending stays set.
- R7: A deferred request sampled at edge E0 loads the countdown value N present at that edge. The target's pending bit is set at edge E0+N+1.
- R8: A deferred request to a core that already holds a waiting deferred request replaces it and restarts the countdown from the current value.
- R9: A retract request cancels a waiting deferred request for its target and leaves an already set pending bit unchanged.
- R10: `wake` of a core is high when that core is pending, `core_idle` is high, and since the bit was last clear an immediate request or a fired deferred request has set it. A no-wake request sets pending without enabling wake.
- R11: The countdown register resets to 0, loads `cnt_wr_val` at an edge where `cnt_wr_en` is 1, and holds its value otherwise. It is visible on `cur_delay`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request word is presented this cycle |
| req_global | input | 1 | 1 = global path (cluster from word), 0 = local path |
| req_src | input | SRC_W | Flat index of the requesting core |
| req_word | input | 32 | Request word (core, cluster, kind) |
| sr_wr_en | input | NCORE | Per-core status register write strobe |
| sr_wr_bit0 | input | NCORE | Bit 0 of each core's status write data |
| cnt_wr_en | input | 1 | Countdown register write strobe |
| cnt_wr_val | input | CNT_W | Countdown value to load |
| core_idle | input | NCORE | Per-core idle indication |
| pending | output | NCORE | Per-core pending status bit |
| fiq | output | NCORE | Per-core fast-interrupt level |
| wake | output | NCORE | Per-core wake request |
| cur_delay | output | CNT_W | Current countdown register value |

## Verification
The assertions take for granted that `req_src` always names an existing core, so that the local path resolves to a real cluster. They also assume that all inputs hold known values from reset onward. The bench changes inputs only just after a rising edge. It draws `req_src` from the valid core range. It lets the cluster and core fields of request words run one past their limits, so that dropped requests are still exercised without breaking the source-index assumption.

// File: rtl/fipi_pkg.sv
package fipi_pkg;

    typedef enum logic [1:0] {
        RQ_NOW    = 2'd0,
        RQ_CANCEL = 2'd1,
        RQ_LATER  = 2'd2,
        RQ_QUIET  = 2'd3
    } rq_kind_e;

    localparam int unsigned CORE_LSB  = 0;
    localparam int unsigned CLUS_LSB  = 16;
    localparam int unsigned KIND_LSB  = 28;
    localparam int unsigned FIELD_W   = 8;

endpackage

// File: rtl/fipi_decode.sv
module fipi_decode
    import fipi_pkg::*;
#(
    parameter int unsigned NCL   = 2,
    parameter int unsigned CPC   = 4,
    parameter int unsigned NCORE = NCL * CPC,
    parameter int unsigned SRC_W = $clog2(NCORE)
) (
    input  logic               req_valid,
    input  logic               req_global,
    input  logic [SRC_W-1:0]   req_src,
    input  logic [31:0]        req_word,
    output logic [NCORE-1:0]   hit,
    output rq_kind_e           kind
);

    int unsigned cl_i;
    int unsigned co_i;
    int unsigned flat_i;
    logic        in_range;
    logic        unused_bits;

    assign unused_bits = ^{req_word[31:30], req_word[27:24], req_word[15:8]};

    always_comb begin
        co_i     = 32'(req_word[CORE_LSB +: FIELD_W]);
        cl_i     = req_global ? 32'(req_word[CLUS_LSB +: FIELD_W])
                              : 32'(req_src) / CPC;
        in_range = req_valid && (cl_i < NCL) && (co_i < CPC);
        flat_i   = cl_i * CPC + co_i;
        kind     = rq_kind_e'(req_word[KIND_LSB +: 2]);
        for (int i = 0; i < NCORE; i++) begin
            hit[i] = in_range && (flat_i == 32'(i));
        end
    end

endmodule

// File: rtl/fipi_slot.sv
module fipi_slot
    import fipi_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  rq_kind_e         kind,
    input  logic             clr,
    input  logic [CNT_W-1:0] delay,
    input  logic             idle,
    output logic             pend,
    output logic             wake
);

    typedef struct packed {
        logic             pend;
        logic             wk;
        logic             armed;
        logic [CNT_W-1:0] tmr;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  set_p;
    logic  set_w;

    always_comb begin
        slot_d = slot_q;
        set_p  = 1'b0;
        set_w  = 1'b0;

        if (hit && kind == RQ_CANCEL) begin
            slot_d.armed = 1'b0;
        end else if (hit && kind == RQ_LATER) begin
            slot_d.armed = 1'b1;
            slot_d.tmr   = delay;
        end else if (slot_q.armed) begin
            if (slot_q.tmr == '0) begin
                set_p        = 1'b1;
                set_w        = 1'b1;
                slot_d.armed = 1'b0;
            end else begin
                slot_d.tmr = slot_q.tmr - 1'b1;
            end
        end

        if (hit && kind == RQ_NOW) begin
            set_p = 1'b1;
            set_w = 1'b1;
        end
        if (hit && kind == RQ_QUIET) begin
            set_p = 1'b1;
        end

        slot_d.pend = set_p | (slot_q.pend & ~clr);
        slot_d.wk   = set_w | (slot_q.wk & slot_d.pend);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign pend = slot_q.pend;
    assign wake = slot_q.pend & slot_q.wk & idle;

endmodule

// File: rtl/fipi_ctrl.sv
module fipi_ctrl
    import fipi_pkg::*;
#(
    parameter int unsigned NCL   = 2,
    parameter int unsigned CPC   = 4,
    parameter int unsigned CNT_W = 8,
    localparam int unsigned NCORE = NCL * CPC,
    localparam int unsigned SRC_W = $clog2(NCORE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_global,
    input  logic [SRC_W-1:0] req_src,
    input  logic [31:0]      req_word,
    input  logic [NCORE-1:0] sr_wr_en,
    input  logic [NCORE-1:0] sr_wr_bit0,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_val,
    input  logic [NCORE-1:0] core_idle,
    output logic [NCORE-1:0] pending,
    output logic [NCORE-1:0] fiq,
    output logic [NCORE-1:0] wake,
    output logic [CNT_W-1:0] cur_delay
);

    typedef struct packed {
        logic [CNT_W-1:0] delay;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic [NCORE-1:0] hit;
    rq_kind_e         kind;
    logic [NCORE-1:0] clr;

    fipi_decode #(
        .NCL   (NCL),
        .CPC   (CPC),
        .NCORE (NCORE),
        .SRC_W (SRC_W)
    ) u_dec (
        .req_valid  (req_valid),
        .req_global (req_global),
        .req_src    (req_src),
        .req_word   (req_word),
        .hit        (hit),
        .kind       (kind)
    );

    assign clr = sr_wr_en & sr_wr_bit0;

    for (genvar g = 0; g < NCORE; g++) begin : g_slot
        fipi_slot #(.CNT_W(CNT_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit[g]),
            .kind  (kind),
            .clr   (clr[g]),
            .delay (ctl_q.delay),
            .idle  (core_idle[g]),
            .pend  (pending[g]),
            .wake  (wake[g])
        );
    end

    always_comb begin
        ctl_d = ctl_q;
        if (cnt_wr_en) begin
            ctl_d.delay = cnt_wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign fiq       = pending;
    assign cur_delay = ctl_q.delay;

endmodule

// File: rtl/fipi_chk.sv
module fipi_chk #(
    parameter int unsigned NCL   = 2,
    parameter int unsigned CPC   = 4,
    parameter int unsigned CNT_W = 8,
    localparam int unsigned NCORE = NCL * CPC,
    localparam int unsigned SRC_W = $clog2(NCORE)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_global,
    input logic [SRC_W-1:0] req_src,
    input logic [31:0]      req_word,
    input logic [NCORE-1:0] sr_wr_en,
    input logic [NCORE-1:0] sr_wr_bit0,
    input logic             cnt_wr_en,
    input logic [CNT_W-1:0] cnt_wr_val,
    input logic [NCORE-1:0] pending
);

    logic [NCORE-1:0] tmask;
    logic [1:0]       rkind;
    logic             unused_chk;
    int unsigned      tcl;
    int unsigned      tco;

    assign unused_chk = ^{req_word[31:30], req_word[27:24], req_word[15:8]};
    assign rkind      = req_word[29:28];

    always_comb begin
        tco   = 32'(req_word[7:0]);
        tcl   = req_global ? 32'(req_word[23:16]) : (32'(req_src) / CPC);
        tmask = '0;
        if (req_valid && tcl < NCL && tco < CPC) begin
            tmask = {{(NCORE-1){1'b0}}, 1'b1} << (tcl * CPC + tco);
        end
    end

    AST_IMM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rkind == 2'd0) |=> ((pending & $past(tmask)) == $past(tmask))); // R4

    AST_QUIET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rkind == 2'd3) |=> ((pending & $past(tmask)) == $past(tmask))); // R10

    AST_W1C_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pending) & ~pending & ~$past(sr_wr_en & sr_wr_bit0)) == '0)); // R5

    AST_DELAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr_en |=> $stable(fipi_ctrl.cur_delay)); // R11

    AST_DELAY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_en |=> (fipi_ctrl.cur_delay == $past(cnt_wr_val))); // R11

endmodule

bind fipi_ctrl fipi_chk #(.NCL(NCL), .CPC(CPC), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_fipi_ctrl.sv
module tb_fipi_ctrl;

    localparam int PERIOD = 10;
    localparam int NCL    = 2;
    localparam int CPC    = 4;
    localparam int CNT_W  = 8;
    localparam int NCORE  = NCL * CPC;
    localparam int SRC_W  = $clog2(NCORE);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_global = 1'b0;
    logic [SRC_W-1:0] req_src = '0;
    logic [31:0]      req_word = '0;
    logic [NCORE-1:0] sr_wr_en = '0;
    logic [NCORE-1:0] sr_wr_bit0 = '0;
    logic             cnt_wr_en = 1'b0;
    logic [CNT_W-1:0] cnt_wr_val = '0;
    logic [NCORE-1:0] core_idle = '0;
    logic [NCORE-1:0] pending;
    logic [NCORE-1:0] fiq;
    logic [NCORE-1:0] wake;
    logic [CNT_W-1:0] cur_delay;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #(PERIOD/2) clk = ~clk;

    fipi_ctrl #(.NCL(NCL), .CPC(CPC), .CNT_W(CNT_W)) dut (.*);

    // behavioural reference model
    int m_pend [NCORE];
    int m_wk   [NCORE];
    int m_arm  [NCORE];
    int m_tmr  [NCORE];
    int m_delay;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCORE; i++) begin
                m_pend[i] = 0; m_wk[i] = 0; m_arm[i] = 0; m_tmr[i] = 0;
            end
            m_delay = 0;
        end else begin
            int co, cl, tg, kd;
            bit ok;
            co = int'(req_word[7:0]);
            cl = req_global ? int'(req_word[23:16]) : int'(req_src) / CPC;
            kd = int'(req_word[29:28]);
            ok = req_valid && cl < NCL && co < CPC;
            tg = cl * CPC + co;
            for (int i = 0; i < NCORE; i++) begin
                bit h, s, w, c;
                h = ok && (tg == i);
                s = 0; w = 0;
                if (h && kd == 1) m_arm[i] = 0;
                else if (h && kd == 2) begin m_arm[i] = 1; m_tmr[i] = m_delay; end
                else if (m_arm[i] != 0) begin
                    if (m_tmr[i] == 0) begin s = 1; w = 1; m_arm[i] = 0; end
                    else m_tmr[i] = m_tmr[i] - 1;
                end
                if (h && kd == 0) begin s = 1; w = 1; end
                if (h && kd == 3) s = 1;
                c = sr_wr_en[i] && sr_wr_bit0[i];
                m_pend[i] = (s || (m_pend[i] != 0 && !c)) ? 1 : 0;
                m_wk[i]   = (w || (m_wk[i] != 0 && m_pend[i] != 0)) ? 1 : 0;
            end
            if (cnt_wr_en) m_delay = int'(cnt_wr_val);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [NCORE-1:0] ep, ew;
            for (int i = 0; i < NCORE; i++) begin
                ep[i] = (m_pend[i] != 0);
                ew[i] = (m_pend[i] != 0) && (m_wk[i] != 0) && core_idle[i];
            end
            chk("R4 R7 pending vs model", 32'(pending), 32'(ep));
            chk("R4 fiq vs model", 32'(fiq), 32'(ep));
            chk("R10 wake vs model", 32'(wake), 32'(ew));
            chk("R11 delay vs model", 32'(cur_delay), 32'(m_delay));
        end
    end

    function automatic logic [31:0] mkw(input int kd, input int cl, input int co);
        return {2'b00, 2'(kd), 4'b0000, 8'(cl), 8'h00, 8'(co)};
    endfunction

    task automatic step(input logic v, input logic g, input int src, input logic [31:0] w,
                        input logic [NCORE-1:0] en, input logic [NCORE-1:0] b0);
        @(posedge clk); #1;
        req_valid = v; req_global = g; req_src = SRC_W'(src); req_word = w;
        sr_wr_en = en; sr_wr_bit0 = b0;
        @(posedge clk); #1;
        req_valid = 1'b0; sr_wr_en = '0; sr_wr_bit0 = '0;
    endtask

    task automatic set_delay(input int v);
        @(posedge clk); #1;
        cnt_wr_en = 1'b1; cnt_wr_val = CNT_W'(v);
        @(posedge clk); #1;
        cnt_wr_en = 1'b0;
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R4 reset pending", 32'(pending), 0);
        chk("R11 reset delay", 32'(cur_delay), 0);

        // R2: local from src 6 (cluster 1), cluster field 0 ignored -> core 6
        step(1, 0, 6, mkw(0, 0, 2), '0, '0);
        @(negedge clk);
        chk("R2 R4 local immediate", 32'(pending), 32'h40);
        chk("R4 fiq level", 32'(fiq), 32'h40);
        // R1 R2: global cluster 0 core 1 from src 6
        step(1, 1, 6, mkw(0, 0, 1), '0, '0);
        @(negedge clk);
        chk("R1 R2 global immediate", 32'(pending), 32'h42);
        // R3: out-of-range cluster and core
        step(1, 1, 0, mkw(0, 2, 0), '0, '0);
        step(1, 0, 0, mkw(0, 0, 4), '0, '0);
        @(negedge clk);
        chk("R3 ignored target", 32'(pending), 32'h42);
        // R5
        step(0, 0, 0, 0, 8'h40, 8'h00);
        @(negedge clk);
        chk("R5 write zero no effect", 32'(pending), 32'h42);
        step(0, 0, 0, 0, 8'h40, 8'h40);
        @(negedge clk);
        chk("R5 write one clears", 32'(pending), 32'h02);
        // R6
        step(1, 0, 0, mkw(0, 0, 1), 8'h02, 8'h02);
        @(negedge clk);
        chk("R6 set beats clear", 32'(pending), 32'h02);
        step(0, 0, 0, 0, 8'h02, 8'h02);
        // R7 and R11
        set_delay(3);
        @(negedge clk);
        chk("R11 countdown load", 32'(cur_delay), 3);
        step(1, 0, 0, mkw(2, 0, 3), '0, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 not yet fired", 32'(pending[3]), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R7 fired at N+1", 32'(pending[3]), 1);
        // R8
        step(0, 0, 0, 0, 8'h08, 8'h08);
        step(1, 0, 0, mkw(2, 0, 2), '0, '0);
        @(posedge clk);
        step(1, 0, 0, mkw(2, 0, 2), '0, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 restart delays firing", 32'(pending[2]), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R8 fires after restart", 32'(pending[2]), 1);
        // R9
        step(1, 0, 0, mkw(2, 0, 0), '0, '0);
        step(1, 0, 0, mkw(1, 0, 0), '0, '0);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R9 retract cancels", 32'(pending[0]), 0);
        step(1, 0, 0, mkw(1, 0, 2), '0, '0);
        @(negedge clk);
        chk("R9 retract keeps pending", 32'(pending[2]), 1);
        // R10
        @(posedge clk); #1 core_idle = '1;
        @(negedge clk);
        chk("R10 deferred wakes", 32'(wake[2]), 1);
        step(1, 1, 0, mkw(0, 1, 0), '0, '0);
        step(1, 1, 0, mkw(3, 1, 1), '0, '0);
        @(negedge clk);
        chk("R10 immediate wakes", 32'(wake[4]), 1);
        chk("R10 quiet sets pending", 32'(pending[5]), 1);
        chk("R10 quiet no wake", 32'(wake[5]), 0);
        @(posedge clk); #1 core_idle[4] = 1'b0;
        @(negedge clk);
        chk("R10 busy core no wake", 32'(wake[4]), 0);
        // R7 zero delay
        set_delay(0);
        step(1, 1, 0, mkw(2, 1, 3), '0, '0);
        @(negedge clk);
        chk("R7 zero delay not at E0", 32'(pending[7]), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R7 zero delay fires", 32'(pending[7]), 1);

        // random traffic, checked by the model every clock
        for (int k = 0; k < 3000; k++) begin
            @(posedge clk); #1;
            req_valid  = ($urandom % 3) == 0;
            req_global = $urandom % 2;
            req_src    = SRC_W'($urandom % NCORE);
            req_word   = mkw(int'($urandom % 4), int'($urandom % (NCL + 1)),
                             int'($urandom % (CPC + 1)));
            sr_wr_en   = NCORE'($urandom) & NCORE'($urandom);
            sr_wr_bit0 = NCORE'($urandom);
            cnt_wr_en  = ($urandom % 16) == 0;
            cnt_wr_val = CNT_W'($urandom % 6);
            core_idle  = NCORE'($urandom);
        end
        @(posedge clk); #1;
        req_valid = 1'b0; sr_wr_en = '0; cnt_wr_en = 1'b0;
        @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule